// File: doc/BRIEF.md
# Occupancy-Ranked Fetch Thread Selector

This block sits in the front end of a simultaneous multithreaded core with eight hardware contexts. Each cycle it picks up to two contexts that may fetch, and ranks them so that the first pick gets first claim on fetch bandwidth. A context can be picked only when it is valid and is not waiting on an instruction cache miss. Among those contexts, the one with the fewest instructions in the decode, rename and queue stages ranks highest.

A mode input can put a branch count in front of that occupancy count. In one mode the primary key is the number of unresolved branches with low prediction confidence. In the other it is the total number of unresolved branches. In both cases fewer is better, and occupancy breaks ties between equal branch counts. Any tie left after that goes to the lowest context index. The result is registered once per cycle.

Each pick comes out as a one-hot grant vector together with a fetch width. When two contexts are picked, each fetches four instructions. When only one context is eligible, it may use the full eight-instruction bandwidth.

Top module: `fetch_thread_sel`

## Requirements
- R1: While rst_ni is low, both grant vectors and both width outputs are zero.
- R2: A context whose valid bit is 0, or whose miss bit is 1, is never granted.
- R3: In mode 0, the first grant goes to the eligible context with the smallest occupancy count.
- R4: The second grant goes to the best-ranked eligible context other than the first. It is zero when fewer than two contexts are eligible, and it never equals the first grant.
- R5: In mode 1, contexts are ranked first by their low-confidence branch count, smallest first. Occupancy count breaks ties.
- R6: In mode 2, contexts are ranked first by their total unresolved branch count, smallest first. Occupancy count breaks ties.
- R7: When two contexts are equal on every key of the active mode, the lower context index ranks higher.
- R8: When exactly one context is eligible, width0 is 8 and width1 is 0. When two or more are eligible, both widths are 4. When no context is eligible, the grants and widths are all zero.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge, and stay unchanged between edges.
- R10: Mode value 3 ranks contexts exactly as mode 0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 occupancy, 1 low-confidence first, 2 all-branches first, 3 same as 0 |
| valid_i | input | 8 | Per-context active flag |
| miss_i | input | 8 | Per-context instruction cache miss pending |
| icount_i | input | 40 | Per-context occupancy count, 5 bits each, context k at bits [5k+4:5k] |
| br_all_i | input | 24 | Per-context unresolved branch count, 3 bits each, context k at bits [3k+2:3k] |
| br_low_i | input | 24 | Per-context low-confidence branch count, 3 bits each, context k at bits [3k+2:3k] |
| grant0_o | output | 8 | One-hot first pick, or zero |
| grant1_o | output | 8 | One-hot second pick, or zero |
| width0_o | output | 4 | Instructions allowed for the first pick |
| width1_o | output | 4 | Instructions allowed for the second pick |

## Verification
Miss exclusion and ranking act in the same cycle when the context holding the best key also has a miss pending. The bench provokes this by setting the miss bit on the lowest-count context and checking that the next-best context is promoted to the first grant. The same pattern is then used with only one other eligible context, to check that the promoted pick also takes the full eight-instruction width. A pseudo-random sweep draws counts from a small range, so that ties and masked minima occur often in every mode, and compares all four outputs against an arithmetic ranking model in the bench.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  typedef enum logic [1:0] {
    MODE_OCC  = 2'd0,
    MODE_LOWC = 2'd1,
    MODE_ALLB = 2'd2,
    MODE_RSVD = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/fsel_key.sv
module fsel_key #(
  parameter int CNT_W = 5,
  parameter int BR_W  = 3,
  localparam int KEY_W = BR_W + CNT_W
) (
  input  fsel_pkg::sel_mode_e mode_i,
  input  logic                valid_i,
  input  logic                miss_i,
  input  logic [CNT_W-1:0]    icount_i,
  input  logic [BR_W-1:0]     br_all_i,
  input  logic [BR_W-1:0]     br_low_i,
  output logic                elig_o,
  output logic [KEY_W-1:0]    key_o
);
  logic [BR_W-1:0] prim;

  always_comb begin
    case (mode_i)
      fsel_pkg::MODE_LOWC: prim = br_low_i;
      fsel_pkg::MODE_ALLB: prim = br_all_i;
      default:             prim = '0;
    endcase
  end

  assign elig_o = valid_i & ~miss_i;
  // branch count is the major key, occupancy the minor key
  assign key_o  = {prim, icount_i};
endmodule

// File: rtl/fsel_pick.sv
module fsel_pick #(
  parameter int N     = 8,
  parameter int KEY_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       elig_i,
  input  logic [N-1:0]       mask_i,
  input  logic [N*KEY_W-1:0] keys_i,
  output logic               found_o,
  output logic [N-1:0]       onehot_o
);
  logic [KEY_W-1:0] best_key;
  logic [IDX_W-1:0] best_idx;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    found_o  = 1'b0;
    best_key = '0;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && !mask_i[i] &&
          (!found_o || keys_i[i*KEY_W +: KEY_W] < best_key)) begin
        found_o  = 1'b1;
        best_key = keys_i[i*KEY_W +: KEY_W];
        best_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    onehot_o = '0;
    if (found_o) onehot_o[best_idx] = 1'b1;
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int N_CTX   = 8,
  parameter int CNT_W   = 5,
  parameter int BR_W    = 3,
  parameter int FETCH_W = 4,
  localparam int KEY_W = BR_W + CNT_W,
  localparam int WID_W = $clog2(2 * FETCH_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             mode_i,
  input  logic [N_CTX-1:0]       valid_i,
  input  logic [N_CTX-1:0]       miss_i,
  input  logic [N_CTX*CNT_W-1:0] icount_i,
  input  logic [N_CTX*BR_W-1:0]  br_all_i,
  input  logic [N_CTX*BR_W-1:0]  br_low_i,
  output logic [N_CTX-1:0]       grant0_o,
  output logic [N_CTX-1:0]       grant1_o,
  output logic [WID_W-1:0]       width0_o,
  output logic [WID_W-1:0]       width1_o
);
  fsel_pkg::sel_mode_e mode;
  logic [N_CTX-1:0]       elig;
  logic [N_CTX*KEY_W-1:0] keys;
  logic                   found0, found1;
  logic [N_CTX-1:0]       pick0, pick1;
  logic [WID_W-1:0]       w0_d, w1_d;

  assign mode = fsel_pkg::sel_mode_e'(mode_i);

  for (genvar g = 0; g < N_CTX; g++) begin : g_key
    fsel_key #(.CNT_W(CNT_W), .BR_W(BR_W)) u_key (
      .mode_i   (mode),
      .valid_i  (valid_i[g]),
      .miss_i   (miss_i[g]),
      .icount_i (icount_i[g*CNT_W +: CNT_W]),
      .br_all_i (br_all_i[g*BR_W +: BR_W]),
      .br_low_i (br_low_i[g*BR_W +: BR_W]),
      .elig_o   (elig[g]),
      .key_o    (keys[g*KEY_W +: KEY_W])
    );
  end

  fsel_pick #(.N(N_CTX), .KEY_W(KEY_W)) u_pick0 (
    .elig_i   (elig),
    .mask_i   ({N_CTX{1'b0}}),
    .keys_i   (keys),
    .found_o  (found0),
    .onehot_o (pick0)
  );

  // second pick: same ranking with the first winner masked
  fsel_pick #(.N(N_CTX), .KEY_W(KEY_W)) u_pick1 (
    .elig_i   (elig),
    .mask_i   (pick0),
    .keys_i   (keys),
    .found_o  (found1),
    .onehot_o (pick1)
  );

  always_comb begin
    w0_d = '0;
    w1_d = '0;
    if (found1) begin
      w0_d = WID_W'(FETCH_W);
      w1_d = WID_W'(FETCH_W);
    end else if (found0) begin
      w0_d = WID_W'(2 * FETCH_W);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant0_o <= '0;
      grant1_o <= '0;
      width0_o <= '0;
      width1_o <= '0;
    end else begin
      grant0_o <= pick0;
      grant1_o <= pick1;
      width0_o <= w0_d;
      width1_o <= w1_d;
    end
  end
endmodule

// File: rtl/fsel_chk.sv
module fsel_chk #(
  parameter int N_CTX   = 8,
  parameter int FETCH_W = 4,
  parameter int WID_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CTX-1:0] valid_i,
  input logic [N_CTX-1:0] miss_i,
  input logic [N_CTX-1:0] grant0_o,
  input logic [N_CTX-1:0] grant1_o,
  input logic [WID_W-1:0] width0_o,
  input logic [WID_W-1:0] width1_o
);
  AST_GRANT0_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant0_o)) else $error("grant0 not one-hot"); // R4

  AST_GRANT1_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant1_o)) else $error("grant1 not one-hot"); // R4

  AST_GRANTS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant0_o & grant1_o) == '0) else $error("grants overlap"); // R4

  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant1_o != '0) |-> (grant0_o != '0)) else $error("grant1 without grant0"); // R4

  AST_NO_INELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant0_o | grant1_o) & $past(~valid_i | miss_i)) == '0)
    else $error("ineligible context granted"); // R2

  AST_SOLO_FULL_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant0_o != '0 && grant1_o == '0) |-> (width0_o == WID_W'(2*FETCH_W) && width1_o == '0))
    else $error("single pick width wrong"); // R8

  AST_PAIR_SPLIT_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant1_o != '0) |-> (width0_o == WID_W'(FETCH_W) && width1_o == WID_W'(FETCH_W)))
    else $error("paired width wrong"); // R8

  AST_IDLE_ZERO_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant0_o == '0) |-> (width0_o == '0 && width1_o == '0))
    else $error("width without grant"); // R8
endmodule

bind fetch_thread_sel fsel_chk #(.N_CTX(N_CTX), .FETCH_W(FETCH_W), .WID_W(WID_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .miss_i   (miss_i),
  .grant0_o (grant0_o),
  .grant1_o (grant1_o),
  .width0_o (width0_o),
  .width1_o (width1_o)
);

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb;
  localparam int N = 8, CW = 5, BW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode;
  logic [N-1:0] valid, miss;
  logic [N*CW-1:0] icount;
  logic [N*BW-1:0] br_all, br_low;
  logic [N-1:0] g0, g1;
  logic [3:0] w0, w1;

  int ic[N], ba[N], bl[N];
  bit v[N], m[N];
  int md;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_thread_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .valid_i(valid), .miss_i(miss),
    .icount_i(icount), .br_all_i(br_all), .br_low_i(br_low),
    .grant0_o(g0), .grant1_o(g1), .width0_o(w0), .width1_o(w1));

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pack();
    for (int k = 0; k < N; k++) begin
      valid[k] = v[k];
      miss[k]  = m[k];
      icount[k*CW +: CW] = CW'(ic[k]);
      br_all[k*BW +: BW] = BW'(ba[k]);
      br_low[k*BW +: BW] = BW'(bl[k]);
    end
    mode = 2'(md);
  endtask

  // reference ranking: returns best eligible index other than excl, or -1
  function automatic int ref_pick(input int excl);
    int best = -1;
    int bp = 0, bc = 0, p;
    for (int k = 0; k < N; k++) begin
      if (!v[k] || m[k] || k == excl) continue;
      p = (md == 1) ? bl[k] : (md == 2) ? ba[k] : 0;
      if (best < 0 || p < bp || (p == bp && ic[k] < bc)) begin
        best = k; bp = p; bc = ic[k];
      end
    end
    return best;
  endfunction

  function automatic logic [23:0] expect_out();
    int a, b;
    logic [7:0] ga, gb;
    logic [3:0] wa, wb;
    a = ref_pick(-1);
    b = (a < 0) ? -1 : ref_pick(a);
    ga = (a < 0) ? 8'h0 : 8'(1 << a);
    gb = (b < 0) ? 8'h0 : 8'(1 << b);
    wa = (b >= 0) ? 4'd4 : (a >= 0) ? 4'd8 : 4'd0;
    wb = (b >= 0) ? 4'd4 : 4'd0;
    return {ga, gb, wa, wb};
  endfunction

  task automatic run(input string req);
    pack();
    @(posedge clk); #1;
    chk(req, {g0, g1, w0, w1}, expect_out());
  endtask

  task automatic clear(input int c);
    for (int k = 0; k < N; k++) begin
      v[k] = 1; m[k] = 0; ic[k] = c; ba[k] = 0; bl[k] = 0;
    end
    md = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] prev;
    clear(10);
    pack();
    #12;
    chk("R1 reset", {g0, g1, w0, w1}, 24'h0);
    @(negedge clk); rst_n = 1'b1;

    // R3: distinct occupancy, min at ctx 5, next ctx 2
    clear(20); ic[5] = 3; ic[2] = 7; run("R3 occupancy min");
    // R7: full tie goes to lowest indices
    clear(9); run("R7 tie low index");
    // R2: best context missing, next promoted
    clear(20); ic[5] = 3; ic[2] = 7; ic[6] = 9; m[5] = 1; run("R2 miss masked");
    clear(20); ic[1] = 2; v[1] = 0; ic[4] = 5; run("R2 invalid masked");
    // R8: one eligible after masking -> full width
    clear(1); for (int k = 0; k < N; k++) m[k] = 1; m[3] = 0; run("R8 solo full width");
    clear(1); for (int k = 0; k < N; k++) v[k] = 0; run("R8 none eligible");
    // R5: low-confidence key dominates occupancy
    clear(4); md = 1; for (int k = 0; k < N; k++) bl[k] = 5;
    bl[6] = 1; ic[6] = 30; bl[0] = 2; bl[7] = 2; ic[7] = 1; run("R5 lowconf primary");
    // R6: total branch key dominates, occupancy breaks tie
    clear(4); md = 2; for (int k = 0; k < N; k++) ba[k] = 6;
    ba[2] = 0; ba[5] = 0; ic[2] = 8; ic[5] = 3; bl[4] = 0; run("R6 allbr primary");
    // R10: mode 3 ignores branch counts
    clear(12); md = 3; for (int k = 0; k < N; k++) begin ba[k] = 7 - k; bl[k] = 7 - k; end
    ic[3] = 1; ic[0] = 2; run("R10 mode3 occupancy");

    // R9: outputs hold between edges, update at next edge
    clear(15); ic[4] = 0; pack(); @(posedge clk); #1;
    prev = {g0, g1, w0, w1};
    clear(15); ic[6] = 0; pack(); #1;
    chk("R9 hold before edge", {g0, g1, w0, w1}, prev);
    @(posedge clk); #1;
    chk("R9 update after edge", {g0, g1, w0, w1}, expect_out());

    // R4 sweep: small value ranges create ties and masked minima
    for (int t = 0; t < 4000; t++) begin
      md = t % 4;
      for (int k = 0; k < N; k++) begin
        v[k]  = ($urandom % 8) != 0;
        m[k]  = ($urandom % 4) == 0;
        ic[k] = $urandom % 4;
        ba[k] = $urandom % 3;
        bl[k] = $urandom % 2;
      end
      if (t % 50 == 0) for (int k = 0; k < N; k++) m[k] = (k != t % N);
      run("R4 sweep ranking");
    end

    // R1: asynchronous reset clears outputs mid-run
    clear(3); pack(); #1; rst_n = 1'b0; #1;
    chk("R1 async clear", {g0, g1, w0, w1}, 24'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule